// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst on a synchronous memory. When the address strobe is asserted, the next clock edge captures an external start address, which becomes the first beat. Each later cycle with the advance qualifier high steps the two low address bits to the next beat. A cycle with neither strobe nor advance is a wait state: address and beat index stay where they are.

The step order is set by a mode input that must stay fixed while bursts are running. With the mode low, the two low bits count up modulo four from the start value. With the mode high, they are the start bits XORed with the beat index. A mode pin that is left open should be tied high at the chip level, so the default order is interleaved. The bits above the low two always keep the loaded value. After the fourth beat, the next advance returns to the start address and the same sequence repeats.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first cycle after it, addr_o is all zeros and beat_o is 0.
- R2: A cycle with load_i high makes the next cycle show addr_o equal to the addr_i sampled with it, and beat_o equal to 0.
- R3: When load_i and adv_i are both high, the load wins. The beat index goes to 0, not to the next beat.
- R4: With mode_ilv_i low (linear), addr_o[1:0] equals (start[1:0] + beat_o) modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With mode_ilv_i high (interleaved), addr_o[1:0] equals start[1:0] XOR beat_o. For example, start 01 gives 01, 00, 11, 10.
- R6: addr_o bits above bit 1 change only on a cycle that follows a load.
- R7: A cycle with load_i and adv_i both low leaves addr_o and beat_o unchanged.
- R8: An advance from beat_o = 3 makes beat_o 0 and returns addr_o to the loaded start address.
- R9: An advance without load increments beat_o by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Address strobe: capture addr_i as the first beat |
| addr_i | input | ADDR_W | External start address |
| adv_i | input | 1 | Advance the burst by one beat |
| mode_ilv_i | input | 1 | Order select: 0 linear, 1 interleaved (tie high when unused) |
| addr_o | output | ADDR_W | Current internal burst address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
The corner that is hardest to reach is a wrap after a long run of advances with wait states mixed in. The wrap only happens after exactly four advances with no strobe in between, and random strobes usually interrupt the burst before it gets there. To reach it, the stimulus draws strobes rarely, so bursts often run past the wrap. Directed bursts from every start value, in both orders, then go through five advances each. A directed cycle with strobe and advance asserted together covers the priority case.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // linear order: offset counts up from the start value
  function automatic beat_t lin_offset(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // interleaved order: start bits flipped by the beat index
  function automatic beat_t ilv_offset(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      start_o <= '0;
    else if (load_i) start_o <= addr_i;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(load_i) |-> start_o == $past(addr_i));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  step_i,
  output beat_t beat_o,
  output logic  wrap_o
);
  localparam beat_t LAST = beat_t'((1 << BEAT_W) - 1);

  assign wrap_o = step_i && !clr_i && (beat_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      beat_o <= '0;
    else if (clr_i)  beat_o <= '0;
    else if (step_i) beat_o <= beat_o + beat_t'(1);
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(step_i) && !$past(clr_i) |-> beat_o == beat_t'($past(beat_o) + 1));
  // R3
  beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(clr_i) |-> beat_o == '0);
  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(clr_i) && !$past(step_i) |-> $stable(beat_o));
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import burst_seq_pkg::*;
(
  input  beat_t start_i,
  input  beat_t beat_i,
  input  logic  ilv_i,
  output beat_t off_o
);
  beat_t lin_w, ilv_w;
  assign lin_w = lin_offset(start_i, beat_i);
  assign ilv_w = ilv_offset(start_i, beat_i);
  assign off_o = ilv_i ? ilv_w : lin_w;

  // R5
  always_comb ilv_zero_chk: assert (!(beat_i == '0) || off_o == start_i);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              mode_ilv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_w;
  beat_t             beat_w, off_w;
  logic              wrap_w;

  bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i), .start_o(start_w));

  bseq_beat_ctr u_beat (
    .clk(clk), .rst_n(rst_n), .clr_i(load_i), .step_i(adv_i),
    .beat_o(beat_w), .wrap_o(wrap_w));

  bseq_order u_order (
    .start_i(start_w[BEAT_W-1:0]), .beat_i(beat_w), .ilv_i(mode_ilv_i), .off_o(off_w));

  assign addr_o = {start_w[ADDR_W-1:BEAT_W], off_w};
  assign beat_o = beat_w;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(load_i) |-> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  // R8
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wrap_w) |-> addr_o == start_w);
  // R2
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(load_i) |-> addr_o == $past(addr_i));
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !past_ok |-> addr_o == '0 && beat_o == '0);
  logic [HI_W-1:0] hi_unused;
  assign hi_unused = '0;
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic clk = 0, rst_n = 0, load = 0, adv = 0, mode = 1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;
  int vectors = 0, errors = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr_in), .adv_i(adv),
    .mode_ilv_i(mode), .addr_o(addr_out), .beat_o(beat_out));

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic ilv);
    logic [1:0] r;
    if (ilv) begin
      r[0] = s[0] != b[0];
      r[1] = s[1] != b[1];
    end else begin
      r = 2'((int'(s) + int'(b)) % 4);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [AW-1:0] got_a, logic [1:0] got_b);
    logic [AW-1:0] ea = {m_start[AW-1:2], exp_low(m_start[1:0], m_beat, mode)};
    vectors++;
    if (got_a !== ea || got_b !== m_beat) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d", tag, got_a, got_b, ea, m_beat);
    end
  endtask

  // drive one cycle, update the model, check at the following negedge
  task automatic cyc(logic l, logic [AW-1:0] a, logic v, logic m, string tag);
    load = l; addr_in = a; adv = v; mode = m;
    if (l) begin m_start = a; m_beat = 0; end
    else if (v) m_beat = m_beat + 2'd1;
    @(negedge clk);
    check(tag, addr_out, beat_out);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", addr_out, beat_out);
    rst_n = 1;
    @(negedge clk);
    check("R1", addr_out, beat_out);
    // directed: every start, both orders, five advances to cross the wrap
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1, AW'(19'h2a5c0 | s), 0, m[0], "R2");
        for (int k = 0; k < 5; k++)
          cyc(0, '0, 1, m[0], k == 3 ? "R8" : (m[0] ? "R5" : "R4"));
        cyc(0, '0, 0, m[0], "R7");
      end
    end
    // R3: strobe and advance together
    cyc(1, 19'h11113, 1, 0, "R3");
    cyc(0, '0, 1, 0, "R9");
    cyc(1, 19'h7fff2, 1, 1, "R3");
    cyc(0, '0, 0, 1, "R7");
    // random: rare strobes, mode changed only with a strobe
    begin
      logic rm = 1;
      for (int i = 0; i < 3000; i++) begin
        logic rl = ($urandom % 10) == 0;
        logic rv = ($urandom % 3) != 0;
        if (rl) rm = $urandom % 2;
        cyc(rl, AW'($urandom), rv, rm,
            rl ? "R2" : (!rv ? "R7" : (m_beat == 3 ? "R8" : (rm ? "R5" : "R4"))));
        if (!rl) begin
          vectors++;
          if (addr_out[AW-1:2] !== m_start[AW-1:2]) begin
            errors++;
            $display("FAIL R6 upper=%h expected=%h", addr_out[AW-1:2], m_start[AW-1:2]);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule